// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block is a byte-addressed data cache placed between a processor request port and a line-oriented DRAM port. Each processor request carries a 16-bit address, an operation code and one data byte. The cache keeps one line per index slot, as a direct-mapped store. Writes stay in the cache until the line has to leave it. Misses of either kind allocate the line. Before a new line is fetched, a dirty occupant of the slot is written back whole.

Every request ends with a one-cycle response. The response carries the byte as seen after the access, a hit flag, and the slot's dirty bit as it stood when the request arrived. Cache capacity and line length are power-of-two parameters. With the defaults of 256 bytes and 8-byte lines, the address splits into an 8-bit tag, a 5-bit index and a 3-bit byte offset. Only one request is in flight at a time.

Top module: `wb_dm_cache`

## Requirements
- R1: After reset every slot is invalid and clean: `req_ready` is 1, `resp_valid` and `mem_req_valid` are 0, and the first access to any address is a miss reporting dirty 0. A reset discards dirty data without writing it back.
- R2: `req_op` value 8'hFF means write and 8'h00 means read. The `req_wdata` byte given with a read has no effect on the cached data.
- R3: A read whose slot is valid with a matching tag responds with `resp_hit`=1 and the cached byte, and causes no memory transaction.
- R4: A write hit replaces the addressed byte in the cache, marks the line dirty, causes no memory transaction, and echoes the written byte on `resp_data`.
- R5: A read miss fetches the line at the line-aligned address {tag, index, zero offset} with one refill command, then responds with `resp_hit`=0 and the requested byte.
- R6: A write miss fetches the line first, merges the byte into it and leaves the line dirty.
- R7: On a miss whose slot holds a valid dirty line, that whole line, including every modified byte, is written back at its own line address before the refill command is issued.
- R8: A miss whose slot is invalid or clean issues no write-back.
- R9: `resp_dirty` equals the slot's dirty bit before the access, for hits and misses alike.
- R10: Once a request is accepted, `req_ready` stays 0 and no memory command starts outside that request until its response. `resp_valid` is a single-cycle pulse, given once per request, two cycles after acceptance on a hit.
- R11: A memory command keeps `mem_req_valid`, `mem_req_write`, `mem_req_addr` and `mem_req_wdata` unchanged until `mem_req_ready` is seen. Refill data is taken on the cycle `mem_rvalid` is 1.
- R12: Addresses with equal index bits (address bits 7:3 by default) but different tags (bits 15:8) compete for one slot, so accessing one evicts the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | 16 | Byte address |
| req_op | input | 8 | 8'hFF write, 8'h00 read |
| req_wdata | input | 8 | Byte to write |
| resp_valid | output | 1 | Response pulse |
| resp_data | output | 8 | Byte after the access |
| resp_hit | output | 1 | 1 hit, 0 miss |
| resp_dirty | output | 1 | Slot dirty bit before the access |
| mem_req_valid | output | 1 | Memory command present |
| mem_req_write | output | 1 | 1 write-back, 0 refill |
| mem_req_addr | output | 16 | Line-aligned memory address |
| mem_req_wdata | output | 64 | Line written back |
| mem_req_ready | input | 1 | Memory accepts the command |
| mem_rvalid | input | 1 | Refill data present |
| mem_rdata | input | 64 | Refill line |

## Verification
The properties assume that the memory side behaves as a simple slave. It raises `mem_req_ready` only while a command is pending. It returns `mem_rvalid` only after a refill has been accepted. It never presents read data for a write-back. The properties also assume that the processor side leaves `req_valid` asserted until the request is taken. The bench meets these assumptions in two ways. Its memory responder reacts only to a visible command and answers each refill exactly once. Its request task holds each request until acceptance and waits for the response before it issues the next one. Response latency on the memory side is varied so that the hold-until-accepted rule is exercised over several cycles.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  localparam logic [7:0] OP_WRITE = 8'hFF;
  localparam logic [7:0] OP_READ  = 8'h00;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_REFILL,
    ST_RWAIT
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = 5,
  parameter int TAG_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             we,
  input  logic [TAG_W-1:0] wtag,
  input  logic             wdirty
);
  logic [NUM_LINES-1:0] valid_r;
  logic [NUM_LINES-1:0] dirty_r;
  logic [TAG_W-1:0]     tag_r [NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_r <= '0;
      dirty_r <= '0;
    end else if (we) begin
      valid_r[idx] <= 1'b1;
      dirty_r[idx] <= wdirty;
    end
  end

  always_ff @(posedge clk) begin
    if (we) tag_r[idx] <= wtag;
  end

  assign rd_valid = valid_r[idx];
  assign rd_dirty = dirty_r[idx];
  assign rd_tag   = tag_r[idx];
endmodule

// File: rtl/dmc_line_ram.sv
module dmc_line_ram #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = 5,
  parameter int LINE_W    = 64
) (
  input  logic              clk,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [LINE_W-1:0] rdata,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [LINE_W-1:0] wdata
);
  logic [LINE_W-1:0] store [NUM_LINES];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 8,
  parameter int OFF_W      = 3,
  parameter int IDX_W      = 5,
  parameter int TAG_W      = 8,
  parameter int LINE_W     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_op,
  input  logic [7:0]        req_wdata,
  output logic              resp_valid,
  output logic [7:0]        resp_data,
  output logic              resp_hit,
  output logic              resp_dirty,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_rvalid,
  input  logic [LINE_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  ts_idx,
  input  logic              ts_valid,
  input  logic              ts_dirty,
  input  logic [TAG_W-1:0]  ts_tag,
  output logic              ts_we,
  output logic [TAG_W-1:0]  ts_wtag,
  output logic              ts_wdirty,
  output logic              ram_re,
  output logic [IDX_W-1:0]  ram_raddr,
  input  logic [LINE_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_waddr,
  output logic [LINE_W-1:0] ram_wdata
);
  dmc_state_e        state;
  logic [TAG_W-1:0]  tag_q;
  logic [IDX_W-1:0]  idx_q;
  logic [OFF_W-1:0]  off_q;
  logic              wr_q;
  logic [7:0]        wdata_q;
  logic [LINE_W-1:0] victim_q;
  logic [TAG_W-1:0]  victim_tag_q;
  logic              dirty_q;

  logic              accept;
  logic              lookup_hit;
  logic [LINE_W-1:0] base_line;
  logic [LINE_W-1:0] merged_line;
  logic [7:0]        base_byte;
  logic [7:0]        out_byte;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign lookup_hit = ts_valid && (ts_tag == tag_q);

  // Line being completed: cached copy on a hit, memory copy on a refill.
  assign base_line = (state == ST_RWAIT) ? mem_rdata : ram_rdata;

  for (genvar g = 0; g < LINE_BYTES; g++) begin : g_merge
    assign merged_line[g*8 +: 8] =
      (wr_q && (off_q == OFF_W'(g))) ? wdata_q : base_line[g*8 +: 8];
  end

  assign base_byte = base_line[{off_q, 3'b000} +: 8];
  assign out_byte  = wr_q ? wdata_q : base_byte;

  assign ts_idx    = idx_q;
  assign ram_re    = accept;
  assign ram_raddr = req_addr[OFF_W +: IDX_W];
  assign ram_waddr = idx_q;
  assign ram_wdata = merged_line;
  assign ts_wtag   = tag_q;
  assign ts_wdirty = wr_q;

  always_comb begin
    ram_we = 1'b0;
    ts_we  = 1'b0;
    if (state == ST_LOOKUP && lookup_hit && wr_q) begin
      ram_we = 1'b1;
      ts_we  = 1'b1;
    end else if (state == ST_RWAIT && mem_rvalid) begin
      ram_we = 1'b1;
      ts_we  = 1'b1;
    end
  end

  assign mem_req_valid = (state == ST_EVICT) || (state == ST_REFILL);
  assign mem_req_write = (state == ST_EVICT);
  assign mem_req_wdata = victim_q;
  assign mem_req_addr  = (state == ST_EVICT)
                       ? {victim_tag_q, idx_q, {OFF_W{1'b0}}}
                       : {tag_q, idx_q, {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      resp_valid <= 1'b0;
      resp_data  <= '0;
      resp_hit   <= 1'b0;
      resp_dirty <= 1'b0;
      dirty_q    <= 1'b0;
      wr_q       <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            tag_q   <= req_addr[OFF_W+IDX_W +: TAG_W];
            idx_q   <= req_addr[OFF_W +: IDX_W];
            off_q   <= req_addr[OFF_W-1:0];
            wr_q    <= (req_op == OP_WRITE);
            wdata_q <= req_wdata;
            state   <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          dirty_q <= ts_valid && ts_dirty;
          if (lookup_hit) begin
            resp_valid <= 1'b1;
            resp_data  <= out_byte;
            resp_hit   <= 1'b1;
            resp_dirty <= ts_valid && ts_dirty;
            state      <= ST_IDLE;
          end else begin
            victim_q     <= ram_rdata;
            victim_tag_q <= ts_tag;
            state        <= (ts_valid && ts_dirty) ? ST_EVICT : ST_REFILL;
          end
        end
        ST_EVICT: begin
          if (mem_req_ready) state <= ST_REFILL;
        end
        ST_REFILL: begin
          if (mem_req_ready) state <= ST_RWAIT;
        end
        ST_RWAIT: begin
          if (mem_rvalid) begin
            resp_valid <= 1'b1;
            resp_data  <= out_byte;
            resp_hit   <= 1'b0;
            resp_dirty <= dirty_q;
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_dm_cache.sv
module wb_dm_cache #(
  parameter int ADDR_W      = 16,
  parameter int CACHE_BYTES = 256,
  parameter int LINE_BYTES  = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [7:0]            req_op,
  input  logic [7:0]            req_wdata,
  output logic                  resp_valid,
  output logic [7:0]            resp_data,
  output logic                  resp_hit,
  output logic                  resp_dirty,
  output logic                  mem_req_valid,
  output logic                  mem_req_write,
  output logic [ADDR_W-1:0]     mem_req_addr,
  output logic [LINE_BYTES*8-1:0] mem_req_wdata,
  input  logic                  mem_req_ready,
  input  logic                  mem_rvalid,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int NUM_LINES = CACHE_BYTES / LINE_BYTES;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W     = $clog2(NUM_LINES);
  localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W    = LINE_BYTES * 8;

  logic [IDX_W-1:0]  ts_idx;
  logic              ts_valid;
  logic              ts_dirty;
  logic [TAG_W-1:0]  ts_tag;
  logic              ts_we;
  logic [TAG_W-1:0]  ts_wtag;
  logic              ts_wdirty;
  logic              ram_re;
  logic [IDX_W-1:0]  ram_raddr;
  logic [LINE_W-1:0] ram_rdata;
  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [LINE_W-1:0] ram_wdata;

  dmc_ctrl #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W),
    .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_op(req_op), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_hit(resp_hit),
    .resp_dirty(resp_dirty),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_ready(mem_req_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ts_idx(ts_idx), .ts_valid(ts_valid), .ts_dirty(ts_dirty), .ts_tag(ts_tag),
    .ts_we(ts_we), .ts_wtag(ts_wtag), .ts_wdirty(ts_wdirty),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  dmc_tag_store #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_tags (
    .clk(clk), .rst(rst), .idx(ts_idx),
    .rd_valid(ts_valid), .rd_dirty(ts_dirty), .rd_tag(ts_tag),
    .we(ts_we), .wtag(ts_wtag), .wdirty(ts_wdirty)
  );

  dmc_line_ram #(
    .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)
  ) u_ram (
    .clk(clk), .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata),
    .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
  );
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W = 16,
  parameter int LINE_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [LINE_W-1:0] mem_req_wdata,
  input logic              mem_req_ready
);
  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !resp_valid && !mem_req_valid));

  assert_hit_no_memory_R3: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_hit) |-> !$past(mem_req_valid));

  assert_writeback_then_refill_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write && mem_req_ready) |=> (mem_req_valid && !mem_req_write));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !resp_valid));

  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid);

  assert_memory_only_when_busy_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  assert_command_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata)));
endmodule

bind wb_dm_cache dmc_checker #(.ADDR_W(ADDR_W), .LINE_W(LINE_BYTES*8)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit),
  .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_req_ready(mem_req_ready)
);

// File: tb/tb_wb_dm_cache.sv
module tb_wb_dm_cache;
  localparam int LB = 8;
  localparam int LW = LB * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [15:0]   req_addr = '0;
  logic [7:0]    req_op = '0;
  logic [7:0]    req_wdata = '0;
  logic          resp_valid;
  logic [7:0]    resp_data;
  logic          resp_hit;
  logic          resp_dirty;
  logic          mem_req_valid;
  logic          mem_req_write;
  logic [15:0]   mem_req_addr;
  logic [LW-1:0] mem_req_wdata;
  logic          mem_req_ready = 1'b0;
  logic          mem_rvalid = 1'b0;
  logic [LW-1:0] mem_rdata = '0;

  always #5 clk = ~clk;

  wb_dm_cache #(.ADDR_W(16), .CACHE_BYTES(256), .LINE_BYTES(LB)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_op(req_op), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_data(resp_data), .resp_hit(resp_hit),
    .resp_dirty(resp_dirty), .mem_req_valid(mem_req_valid),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_ready(mem_req_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] dram [int];
  int wb_cnt = 0;
  int rf_cnt = 0;
  logic [15:0] last_wb_addr = '0;
  int mem_lat = 1;

  function automatic logic [7:0] dram_byte(int a);
    logic [15:0] x;
    x = 16'(a);
    if (dram.exists(a)) return dram[a];
    return x[7:0] ^ x[15:8] ^ 8'h3C;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Behavioural line memory answering write-back and refill commands.
  initial begin
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rvalid    = 1'b0;
      if (mem_req_valid && !rst) begin
        repeat (mem_lat) @(negedge clk);
        mem_req_ready = 1'b1;
        if (mem_req_write) begin
          for (int b = 0; b < LB; b++)
            dram[int'(mem_req_addr) + b] = mem_req_wdata[b*8 +: 8];
          wb_cnt++;
          last_wb_addr = mem_req_addr;
          @(negedge clk);
          mem_req_ready = 1'b0;
        end else begin
          for (int b = 0; b < LB; b++)
            mem_rdata[b*8 +: 8] = dram_byte(int'(mem_req_addr) + b);
          rf_cnt++;
          @(negedge clk);
          mem_req_ready = 1'b0;
          @(negedge clk);
          mem_rvalid = 1'b1;
          @(negedge clk);
          mem_rvalid = 1'b0;
        end
      end
    end
  end

  task automatic do_req(input logic [15:0] a, input logic [7:0] op, input logic [7:0] wd,
                        output logic [7:0] d, output logic h, output logic dy);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    req_op    = op;
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10", "req_ready while busy", 32'(req_ready), 32'h0);
    while (!resp_valid) @(negedge clk);
    d  = resp_data;
    h  = resp_hit;
    dy = resp_dirty;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  op;
    logic [7:0]  wd;
    logic        hit;
    logic        dirty;
    logic        wb;
    logic [15:0] wb_addr;
    logic [7:0]  data;
  } vec_t;

  localparam int NV = 15;
  // Default memory content is addr[7:0] ^ addr[15:8] ^ 8'h3C.
  localparam vec_t VECS [NV] = '{
    '{16'h0010, 8'h00, 8'hAA, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h2C}, // R1 cold miss
    '{16'h0013, 8'h00, 8'h55, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h2F}, // R3 hit
    '{16'h0013, 8'hFF, 8'h77, 1'b1, 1'b0, 1'b0, 16'h0000, 8'h77}, // R4 write hit
    '{16'h0013, 8'h00, 8'h11, 1'b1, 1'b1, 1'b0, 16'h0000, 8'h77}, // R2 R9
    '{16'h0110, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 16'h0010, 8'h2D}, // R7 R12
    '{16'h0013, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h77}, // R8 refetch
    '{16'h2345, 8'hFF, 8'h9C, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h9C}, // R6 write miss
    '{16'h2345, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 16'h0000, 8'h9C},
    '{16'h2344, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 16'h0000, 8'h5B},
    '{16'h5540, 8'hFF, 8'h01, 1'b0, 1'b1, 1'b1, 16'h2340, 8'h01}, // R6 R7
    '{16'h2345, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 16'h5540, 8'h9C},
    '{16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 8'h3C},
    '{16'hFFF8, 8'hFF, 8'hE1, 1'b1, 1'b0, 1'b0, 16'h0000, 8'hE1},
    '{16'h00F8, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1, 16'hFFF8, 8'hC4},
    '{16'hFFF8, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 8'hE1}
  };

  function automatic string label(vec_t v);
    if (v.wb) return "R7 R9 R12";
    if (!v.hit && v.op == 8'hFF) return "R6 R8";
    if (!v.hit) return "R5 R8 R1";
    if (v.op == 8'hFF) return "R4 R9";
    return "R3 R2 R9";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic h, dy;
    int wb0, rf0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready && !resp_valid && !mem_req_valid, "R1", "idle after reset",
          {29'b0, req_ready, resp_valid, mem_req_valid}, 32'h4);

    for (int i = 0; i < NV; i++) begin
      wb0 = wb_cnt;
      rf0 = rf_cnt;
      mem_lat = (i % 3) + 1;
      do_req(VECS[i].addr, VECS[i].op, VECS[i].wd, d, h, dy);
      check(d == VECS[i].data, label(VECS[i]), $sformatf("vec %0d data", i), 32'(d), 32'(VECS[i].data));
      check(h == VECS[i].hit, label(VECS[i]), $sformatf("vec %0d hit", i), 32'(h), 32'(VECS[i].hit));
      check(dy == VECS[i].dirty, "R9", $sformatf("vec %0d dirty", i), 32'(dy), 32'(VECS[i].dirty));
      check((wb_cnt - wb0) == int'(VECS[i].wb), "R7 R8", $sformatf("vec %0d writebacks", i),
            32'(wb_cnt - wb0), 32'(VECS[i].wb));
      if (VECS[i].wb)
        check(last_wb_addr == VECS[i].wb_addr, "R7", $sformatf("vec %0d wb addr", i),
              32'(last_wb_addr), 32'(VECS[i].wb_addr));
      check((rf_cnt - rf0) == int'(!VECS[i].hit), "R3 R4 R5", $sformatf("vec %0d refills", i),
            32'(rf_cnt - rf0), 32'(!VECS[i].hit));
    end

    // R11: long memory latency keeps the command pending over several cycles.
    mem_lat = 5;
    do_req(16'h0113, 8'hFF, 8'h42, d, h, dy);
    check(h == 1'b0 && dy == 1'b0 && d == 8'h42, "R11", "slow memory write miss",
          {23'b0, h, dy, d[7:0]}, 32'h42);
    mem_lat = 4;
    wb0 = wb_cnt;
    do_req(16'h0013, 8'h00, 8'h00, d, h, dy);
    check(d == 8'h77 && (wb_cnt - wb0) == 1 && last_wb_addr == 16'h0110, "R11",
          "slow memory evict and refill", {16'(last_wb_addr), 8'(wb_cnt - wb0), d}, 32'h0110_0177);
    mem_lat = 1;

    // R1: dirty data written before a reset is lost; the slot reads cold.
    do_req(16'h0013, 8'hFF, 8'h5E, d, h, dy);
    check(h == 1'b1, "R4", "write hit before reset", 32'(h), 32'h1);
    apply_reset();
    check(req_ready && !resp_valid && !mem_req_valid, "R1", "idle after second reset",
          {29'b0, req_ready, resp_valid, mem_req_valid}, 32'h4);
    wb0 = wb_cnt;
    do_req(16'h0013, 8'h00, 8'h00, d, h, dy);
    check(h == 1'b0 && dy == 1'b0, "R1", "miss clean after reset", {30'b0, h, dy}, 32'h0);
    check(d == 8'h77 && wb_cnt == wb0, "R1", "no write-back of discarded line",
          {16'b0, 8'(wb_cnt - wb0), d}, 32'h0077);

    // R2: a non-write op code with a byte attached leaves data untouched.
    do_req(16'h0014, 8'h00, 8'hEE, d, h, dy);
    check(h == 1'b1 && d == dram_byte(16'h0014), "R2", "read wdata ignored",
          32'(d), 32'(dram_byte(16'h0014)));

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule